// File: doc/BRIEF.md
# Configuration Address/Data Port Translator

This block sits on the host side of a host-to-PCI bridge. Host software reaches configuration space through two DWORD I/O ports: an address port that holds a latched configuration address, and a data port that acts as a window onto the register that address names. The translator keeps the latched address and splits it into bus, device, function and register-index fields. For each host access it decides whether the access stays local, which is a full DWORD access to the address port. Otherwise it goes out as a configuration cycle or as an ordinary I/O cycle.

Every access that leaves the block becomes one request record toward a bus-side master. The record carries the cycle kind, the direction, the decoded fields, the byte enables, the write data and a one-hot device select. The host access is held off until the bus side reports completion. Read data then flows back to the host. A configuration read that no device claims returns all ones.

Top module: `cfg_port_xlate`

## Requirements
- R1: After synchronous reset, `h_ready` and `b_req_valid` are low and the latched address reads back as 0.
- R2: A host write to port 0x3F8 with `h_be` = 4'b1111 updates the latch and raises no bus request. Bits [30:24] and [1:0] of the written value are discarded. A read of that port with all four enables returns the latch: enable in bit 31, bus in [23:16], device in [15:11], function in [10:8], register index in [7:2], and zeros elsewhere.
- R3: A host access to port 0x3F8 with any `h_be` other than 4'b1111 is issued as an I/O cycle (`b_is_cfg` = 0, `b_io_addr` = 0x3F8, same enables and data) and leaves the latch unchanged.
- R4: When latch bit 31 is 1, an access to port 0x3FC is issued as a configuration cycle (`b_is_cfg` = 1). Its `b_bus`, `b_dev`, `b_func` and `b_reg` come from the latch, and `b_write`, `b_be` and `b_wdata` come from the host access.
- R5: When latch bit 31 is 0, an access to port 0x3FC is issued as an I/O cycle to address 0x3FC.
- R6: While a configuration request to bus 0 is presented, `b_dev_sel` has exactly bit `b_dev` set and `b_fwd` is 0. For a configuration request to any other bus, `b_dev_sel` is all zero and `b_fwd` is 1. During I/O cycles both are zero.
- R7: Once a request is presented, `b_req_valid` and the record stay stable until `b_done`. `h_ready` is low throughout the request and rises for one cycle in the cycle after `b_done`. It is high in the cycle after acceptance for a local access. `h_rdata` is 0 for writes.
- R8: For a read completed with `b_abort` = 1, `h_rdata` is 32'hFFFFFFFF if the cycle was a configuration read, and `b_rdata` if it was an I/O read. Without abort, a read returns `b_rdata`.
- R9: An access to any port other than 0x3F8 or 0x3FC is issued as an I/O cycle to that port with `b_dev_sel` = 0.
- R10: A local access to the address port never raises `b_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host access request, held until `h_ready` |
| h_ready | output | 1 | Host access completes in this cycle |
| h_write | input | 1 | 1 = write, 0 = read |
| h_port | input | 16 | Host I/O port address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Read data, valid while `h_ready` is high |
| b_req_valid | output | 1 | Request record presented to the bus master |
| b_is_cfg | output | 1 | 1 = configuration cycle, 0 = I/O cycle |
| b_write | output | 1 | Request direction |
| b_io_addr | output | 16 | I/O port of the originating access |
| b_bus | output | 8 | Configuration bus number |
| b_dev | output | 5 | Configuration device number |
| b_func | output | 3 | Configuration function number |
| b_reg | output | 6 | Configuration DWORD register index |
| b_be | output | 4 | Byte enables for the cycle |
| b_wdata | output | 32 | Write data for the cycle |
| b_dev_sel | output | 32 | One-hot device select for bus 0 configuration cycles |
| b_fwd | output | 1 | Configuration cycle targets a bus other than 0 |
| b_done | input | 1 | Bus-side completion pulse |
| b_abort | input | 1 | No target claimed the cycle |
| b_rdata | input | 32 | Bus-side read data, valid with `b_done` |

## Verification
The assertions assume two things about the inputs. The host keeps `h_valid` and the access fields steady until `h_ready`. The bus side pulses `b_done` only while `b_req_valid` is high, and at most once per request. The bench meets both conditions by construction. It sequences each access from a single task that drops `h_valid` in the cycle it sees `h_ready`. It raises `b_done` for exactly one cycle, after a random latency, only once it has seen the request presented.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    localparam int DW     = 32;
    localparam int BE_W   = DW / 8;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int REG_W  = 6;
    localparam int NDEV   = 1 << DEV_W;
    localparam int RSVH_W = DW - 1 - BUS_W - DEV_W - FN_W - REG_W - 2;

    // Field order is fixed: software composes this word directly.
    typedef struct packed {
        logic              en;
        logic [RSVH_W-1:0] rsv_hi;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   func;
        logic [REG_W-1:0]  regn;
        logic [1:0]        rsv_lo;
    } cfg_addr_t;

    typedef enum logic [1:0] {
        RT_LOCAL = 2'd0,
        RT_CFG   = 2'd1,
        RT_IO    = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RESP = 2'd2
    } xst_e;

    typedef struct packed {
        logic             is_cfg;
        logic             write;
        logic [15:0]      io_addr;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  func;
        logic [REG_W-1:0] regn;
        logic [BE_W-1:0]  be;
        logic [DW-1:0]    wdata;
    } bus_req_t;

    // Zero the reserved positions of a raw address word.
    function automatic cfg_addr_t addr_sanitize(input logic [DW-1:0] raw);
        cfg_addr_t a;
        a        = cfg_addr_t'(raw);
        a.rsv_hi = '0;
        a.rsv_lo = '0;
        return a;
    endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
    import cfg_xlate_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output cfg_addr_t     addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (wr_en) begin
            addr_q <= addr_sanitize(wr_data);
        end
    end

endmodule

// File: rtl/cfg_route_dec.sv
module cfg_route_dec
    import cfg_xlate_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] ADDR_PORT = 16'h03F8,
    parameter logic [15:0] DATA_PORT = 16'h03FC
) (
    input  logic [IO_AW-1:0] port,
    input  logic [BE_W-1:0]  be,
    input  logic             cfg_en,
    output route_e           route
);

    logic hit_addr;
    logic hit_data;
    logic full_dw;

    assign hit_addr = (port == IO_AW'(ADDR_PORT));
    assign hit_data = (port == IO_AW'(DATA_PORT));
    assign full_dw  = &be;

    always_comb begin
        if (hit_addr && full_dw) begin
            route = RT_LOCAL;
        end else if (hit_data && cfg_en) begin
            route = RT_CFG;
        end else begin
            route = RT_IO;
        end
    end

endmodule

// File: rtl/cfg_dev_sel.sv
module cfg_dev_sel
    import cfg_xlate_pkg::*;
(
    input  logic             en,
    input  logic [DEV_W-1:0] dev,
    output logic [NDEV-1:0]  sel
);

    for (genvar i = 0; i < NDEV; i++) begin : g_sel
        assign sel[i] = en && (dev == DEV_W'(i));
    end

endmodule

// File: rtl/cfg_port_xlate.sv
module cfg_port_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] ADDR_PORT = 16'h03F8,
    parameter logic [15:0] DATA_PORT = 16'h03FC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_valid,
    output logic             h_ready,
    input  logic             h_write,
    input  logic [IO_AW-1:0] h_port,
    input  logic [BE_W-1:0]  h_be,
    input  logic [DW-1:0]    h_wdata,
    output logic [DW-1:0]    h_rdata,
    output logic             b_req_valid,
    output logic             b_is_cfg,
    output logic             b_write,
    output logic [IO_AW-1:0] b_io_addr,
    output logic [BUS_W-1:0] b_bus,
    output logic [DEV_W-1:0] b_dev,
    output logic [FN_W-1:0]  b_func,
    output logic [REG_W-1:0] b_reg,
    output logic [BE_W-1:0]  b_be,
    output logic [DW-1:0]    b_wdata,
    output logic [NDEV-1:0]  b_dev_sel,
    output logic             b_fwd,
    input  logic             b_done,
    input  logic             b_abort,
    input  logic [DW-1:0]    b_rdata
);

    xst_e      st;
    bus_req_t  req;
    logic [DW-1:0] rdata_q;
    cfg_addr_t addr_q;
    route_e    route;
    logic      accept;
    logic      lat_we;
    logic      bus0;

    cfg_route_dec #(
        .IO_AW    (IO_AW),
        .ADDR_PORT(ADDR_PORT),
        .DATA_PORT(DATA_PORT)
    ) u_dec (
        .port  (h_port),
        .be    (h_be),
        .cfg_en(addr_q.en),
        .route (route)
    );

    assign accept = (st == ST_IDLE) && h_valid;
    assign lat_we = accept && (route == RT_LOCAL) && h_write;

    cfg_addr_latch u_lat (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (lat_we),
        .wr_data(h_wdata),
        .addr_q (addr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            req     <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (h_valid) begin
                        req.is_cfg  <= (route == RT_CFG);
                        req.write   <= h_write;
                        req.io_addr <= 16'(h_port);
                        req.bus     <= addr_q.bus;
                        req.dev     <= addr_q.dev;
                        req.func    <= addr_q.func;
                        req.regn    <= addr_q.regn;
                        req.be      <= h_be;
                        req.wdata   <= h_wdata;
                        if (route == RT_LOCAL) begin
                            rdata_q <= h_write ? '0 : DW'(addr_q);
                            st      <= ST_RESP;
                        end else begin
                            st      <= ST_BUS;
                        end
                    end
                end
                ST_BUS: begin
                    if (b_done) begin
                        if (req.write) begin
                            rdata_q <= '0;
                        end else if (req.is_cfg && b_abort) begin
                            rdata_q <= '1;
                        end else begin
                            rdata_q <= b_rdata;
                        end
                        st <= ST_RESP;
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    assign h_ready     = (st == ST_RESP);
    assign h_rdata     = rdata_q;
    assign b_req_valid = (st == ST_BUS);
    assign b_is_cfg    = req.is_cfg;
    assign b_write     = req.write;
    assign b_io_addr   = IO_AW'(req.io_addr);
    assign b_bus       = req.bus;
    assign b_dev       = req.dev;
    assign b_func      = req.func;
    assign b_reg       = req.regn;
    assign b_be        = req.be;
    assign b_wdata     = req.wdata;

    assign bus0  = (req.bus == '0);
    assign b_fwd = b_req_valid && req.is_cfg && !bus0;

    cfg_dev_sel u_sel (
        .en (b_req_valid && req.is_cfg && bus0),
        .dev(req.dev),
        .sel(b_dev_sel)
    );

endmodule

// File: rtl/cfg_port_xlate_chk.sv
module cfg_port_xlate_chk
    import cfg_xlate_pkg::*;
#(
    parameter int IO_AW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             h_ready,
    input logic             b_req_valid,
    input logic             b_is_cfg,
    input logic             b_write,
    input logic [BUS_W-1:0] b_bus,
    input logic [DEV_W-1:0] b_dev,
    input logic [BE_W-1:0]  b_be,
    input logic [DW-1:0]    b_wdata,
    input logic [IO_AW-1:0] b_io_addr,
    input logic [NDEV-1:0]  b_dev_sel,
    input logic             b_fwd,
    input logic             b_done,
    input logic [DW-1:0]    addr_q
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!h_ready && !b_req_valid));

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_q[30:24] == '0) && (addr_q[1:0] == '0));

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(b_dev_sel));

    // R6
    sel_match_chk: assert property (@(posedge clk) disable iff (rst)
        (b_dev_sel != '0) |-> (b_req_valid && b_is_cfg && (b_bus == '0)
                               && b_dev_sel[b_dev]));

    // R6
    fwd_nosel_chk: assert property (@(posedge clk) disable iff (rst)
        b_fwd |-> (b_dev_sel == '0 && b_is_cfg && b_bus != '0));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (b_req_valid && !b_done) |=> (b_req_valid && $stable(b_wdata)
            && $stable(b_be) && $stable(b_is_cfg) && $stable(b_write)
            && $stable(b_io_addr) && $stable(b_bus) && $stable(b_dev)));

    // R7
    no_early_ready_chk: assert property (@(posedge clk) disable iff (rst)
        b_req_valid |-> !h_ready);

    // R7
    ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (b_req_valid && b_done) |=> (h_ready && !b_req_valid));

endmodule

bind cfg_port_xlate cfg_port_xlate_chk #(.IO_AW(IO_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .h_ready    (h_ready),
    .b_req_valid(b_req_valid),
    .b_is_cfg   (b_is_cfg),
    .b_write    (b_write),
    .b_bus      (b_bus),
    .b_dev      (b_dev),
    .b_be       (b_be),
    .b_wdata    (b_wdata),
    .b_io_addr  (b_io_addr),
    .b_dev_sel  (b_dev_sel),
    .b_fwd      (b_fwd),
    .b_done     (b_done),
    .addr_q     (addr_q)
);

// File: tb/tb_cfg_port_xlate.sv
module tb_cfg_port_xlate;

    localparam logic [15:0] AP = 16'h03F8;
    localparam logic [15:0] DP = 16'h03FC;

    logic        clk = 1'b0;
    logic        rst;
    logic        h_valid, h_ready, h_write;
    logic [15:0] h_port;
    logic [3:0]  h_be;
    logic [31:0] h_wdata, h_rdata;
    logic        b_req_valid, b_is_cfg, b_write, b_fwd;
    logic [15:0] b_io_addr;
    logic [7:0]  b_bus;
    logic [4:0]  b_dev;
    logic [2:0]  b_func;
    logic [5:0]  b_reg;
    logic [3:0]  b_be;
    logic [31:0] b_wdata, b_dev_sel, b_rdata;
    logic        b_done, b_abort;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] lat = 32'h0;

    always #10 clk = ~clk;

    cfg_port_xlate dut (.*);

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] san(input logic [31:0] w);
        return w & 32'h80FF_FFFC;
    endfunction

    // route: 0 local, 1 config, 2 io
    function automatic int exp_route(input logic [15:0] p, input logic [3:0] be);
        if (p == AP && be == 4'hF) return 0;
        if (p == DP && lat[31])     return 1;
        return 2;
    endfunction

    task automatic access(input bit w, input logic [15:0] p, input logic [3:0] be,
                          input logic [31:0] wd, input logic [31:0] brd,
                          input bit abort, input int lat_cyc, input string rq);
        int rt;
        bit seen;
        bit done_prev;
        int waited;
        int guard;
        logic [31:0] exp_rd;
        logic [31:0] exp_sel;
        rt = exp_route(p, be);
        @(negedge clk);
        h_valid = 1'b1; h_write = w; h_port = p; h_be = be; h_wdata = wd;
        seen = 0; done_prev = 0; waited = 0; guard = 0;
        forever begin
            @(negedge clk);
            b_done = 1'b0;
            if (done_prev)
                chk(h_ready, "R7 ready after done", {31'b0, h_ready}, 32'd1);
            if (h_ready) break;
            if (b_req_valid) begin
                if (!seen) begin
                    seen = 1;
                    chk(rt != 0, "R10 local raised bus req", 32'd1, 32'd0);
                    chk(b_is_cfg == (rt == 1), {rq, " R4/R5/R9 kind"},
                        {31'b0, b_is_cfg}, {31'b0, rt == 1});
                    chk(b_write == w && b_be == be && b_io_addr == p,
                        {rq, " R3 record"}, {b_io_addr, 12'b0, b_be},
                        {p, 12'b0, be});
                    if (w)
                        chk(b_wdata == wd, {rq, " R4 wdata"}, b_wdata, wd);
                    if (rt == 1) begin
                        chk({b_bus, b_dev, b_func, b_reg} == {lat[23:16], lat[15:2]},
                            "R4 fields", {10'b0, b_bus, b_dev, b_func, b_reg},
                            {10'b0, lat[23:2]});
                        exp_sel = (lat[23:16] == 8'd0) ? (32'd1 << lat[15:11]) : 32'd0;
                        chk(b_dev_sel == exp_sel, "R6 dev_sel", b_dev_sel, exp_sel);
                        chk(b_fwd == (lat[23:16] != 8'd0), "R6 fwd",
                            {31'b0, b_fwd}, {31'b0, lat[23:16] != 8'd0});
                    end else begin
                        chk(b_dev_sel == 32'd0 && !b_fwd, "R9 no select on io",
                            b_dev_sel, 32'd0);
                    end
                end
                if (waited == lat_cyc) begin
                    b_done = 1'b1; b_rdata = brd; b_abort = abort;
                    done_prev = 1;
                end
                waited++;
            end
            guard++;
            if (guard > 200) begin
                chk(0, {rq, " R7 hang"}, 32'd0, 32'd1);
                break;
            end
        end
        h_valid = 1'b0;
        if (rt == 0) begin
            chk(!seen, "R10 no bus req", {31'b0, seen}, 32'd0);
            exp_rd = w ? 32'd0 : lat;
            if (w) lat = san(wd);
        end else begin
            chk(seen, {rq, " R3/R5/R9 bus req issued"}, {31'b0, seen}, 32'd1);
            if (w)                     exp_rd = 32'd0;
            else if (rt == 1 && abort) exp_rd = 32'hFFFF_FFFF;
            else                       exp_rd = brd;
        end
        chk(h_rdata === exp_rd, {rq, " R2/R8 rdata"}, h_rdata, exp_rd);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; h_valid = 0; h_write = 0; h_port = 0; h_be = 0; h_wdata = 0;
        b_done = 0; b_abort = 0; b_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!h_ready && !b_req_valid, "R1 idle outputs",
            {30'b0, h_ready, b_req_valid}, 32'd0);
        access(0, AP, 4'hF, 0, 0, 0, 0, "R1 latch read");
        // R2 reserved bits dropped
        access(1, AP, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, "R2 write all ones");
        access(0, AP, 4'hF, 0, 0, 0, 0, "R2 readback");
        // R3 byte/word access to address port bypasses latch
        access(1, AP, 4'h1, 32'h0000_0012, 0, 0, 1, "R3 byte write");
        access(0, AP, 4'h3, 0, 32'h1234_5678, 0, 2, "R3 word read");
        access(0, AP, 4'hF, 0, 0, 0, 0, "R3 latch unchanged");
        // R4/R6 bus 0 config
        access(1, AP, 4'hF, 32'h8000_A31C, 0, 0, 0, "R4 set");
        access(0, DP, 4'hF, 0, 32'hCAFE_0001, 0, 0, "R4 cfg read");
        access(0, DP, 4'hF, 0, 32'hCAFE_0002, 1, 3, "R8 cfg abort");
        access(1, DP, 4'h6, 32'hDEAD_BEEF, 0, 0, 2, "R4 cfg write");
        // R6 other bus
        access(1, AP, 4'hF, 32'h8005_F8FC, 0, 0, 0, "R6 set");
        access(0, DP, 4'hF, 0, 32'h0000_0055, 0, 1, "R6 fwd read");
        // R5 disabled window
        access(1, AP, 4'hF, 32'h0005_F8FC, 0, 0, 0, "R5 set");
        access(0, DP, 4'hF, 0, 32'h7777_0000, 1, 1, "R5 io abort R8");
        // R9 other port
        access(1, 16'h0080, 4'h1, 32'h0000_00AA, 0, 0, 0, "R9 other port");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            logic [15:0] p;
            logic [3:0]  be;
            logic [31:0] wd;
            sel = $urandom_range(0, 9);
            be  = ($urandom_range(0, 2) != 0) ? 4'hF : 4'($urandom);
            wd  = $urandom;
            if (sel < 4) begin
                p = AP;
                if ($urandom_range(0, 1) != 0) wd[23:16] = 8'h00;
            end else if (sel < 8) p = DP;
            else                  p = 16'($urandom_range(0, 16'h3F0));
            access($urandom_range(0, 1) != 0, p, be, wd, $urandom,
                   $urandom_range(0, 3) == 0, $urandom_range(0, 4), "rand R4");
        end
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule